// File: doc/BRIEF.md
# Bidirectional Cascadable Row Scan Driver

This block is the logic core of a row scan driver with a configurable number of channels (64 by default). A serial shift register advances one stage on every rising edge of the shift clock. A direction input chooses which way data moves. Each serial pin is modelled as an input, an output and an output enable. The pin that receives data in one direction sends data in the other, so devices can be chained end to end in either direction to cover any number of display rows.

A strobe-controlled latch sits between the shift register and the outputs. While the strobe is low the latch follows the register. While the strobe is high it holds. After the latch, each channel passes through a blanking and polarity stage. Blanking drives every channel to the level set by the polarity input. When blanking is off, polarity chooses between the latched data and its inverse. A synchronous reset clears the register, and the same reset clears the latch while it is asserted, so simulation starts from a known state.

Top module: `row_scan_driver`

## Requirements
- R1: With `fwd` high, every rising edge of `sclk` loads `pa_in` into stage 1 (`drv` bit 0) and moves stage k into stage k+1.
- R2: With `fwd` low, every rising edge of `sclk` loads `pb_in` into the last stage (bit NCH-1) and moves stage k+1 into stage k.
- R3: With `fwd` high, `pb_oe`=1 and `pa_oe`=0. With `fwd` low, `pa_oe`=1 and `pb_oe`=0. `pa_out` always shows stage 1 and `pb_out` always shows the last stage.
- R4: Forward: a bit applied before the first of NCH shifts appears on `pb_out` after the NCH-th shift. Reverse: a bit applied before the first of NCH shifts appears on `pa_out` after the NCH-th shift. Two chained devices therefore pass a bit through in 2·NCH shifts.
- R5: While `stb` is low, the latch follows the shift register, and changes to the register show on `drv` in the same cycle.
- R6: While `stb` is high, the latch keeps its contents, and shifting does not change `drv`.
- R7: While `blank` is high, every bit of `drv` equals `pol`, whatever the latch holds and whatever `stb` is.
- R8: While `blank` is low, `drv` equals the latch contents when `pol`=0 and the inverted latch contents when `pol`=1.
- R9: A rising `sclk` edge with `rst` high clears the shift register. While `rst` is high the latch also reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Shift clock; the register shifts on its rising edge |
| rst | input | 1 | Synchronous clear of the register; also holds the latch at zero |
| fwd | input | 1 | Direction select: 1 for stage 1 toward last stage, 0 for the reverse |
| stb | input | 1 | Latch control: 0 means transparent, 1 means hold |
| blank | input | 1 | Forces every output to the level of `pol` |
| pol | input | 1 | Output polarity: 1 inverts the outputs |
| pa_in | input | 1 | Serial pin A input, used in forward mode |
| pa_out | output | 1 | Serial pin A output value (stage 1) |
| pa_oe | output | 1 | Serial pin A drive enable, high in reverse mode |
| pb_in | input | 1 | Serial pin B input, used in reverse mode |
| pb_out | output | 1 | Serial pin B output value (last stage) |
| pb_oe | output | 1 | Serial pin B drive enable, high in forward mode |
| drv | output | NCH | Per-channel logic-level outputs |

## Verification
The hardest situation to reach from the ports is a bit crossing the boundary between two chained devices, in both directions, with the strobe and blanking state mixed in. Each direction needs long runs of uninterrupted shifting. The bench wires two instances pin to pin. It first runs directed 128-shift passes in each direction and watches the far serial pin. It then runs a long random phase in which the direction rarely flips and strobe, blanking and polarity change often. A reference model of the full 128-stage chain and both latches is compared against both devices on every half cycle.

// File: rtl/row_scan_driver.sv
module row_scan_driver #(
  parameter int unsigned NCH = 64
) (
  input  logic           sclk,
  input  logic           rst,
  input  logic           fwd,
  input  logic           stb,
  input  logic           blank,
  input  logic           pol,
  input  logic           pa_in,
  output logic           pa_out,
  output logic           pa_oe,
  input  logic           pb_in,
  output logic           pb_out,
  output logic           pb_oe,
  output logic [NCH-1:0] drv
);
  localparam int unsigned LAST = NCH - 1;

  logic [NCH-1:0] sr;
  logic [NCH-1:0] lat;

  always_ff @(posedge sclk) begin
    if (rst)      sr <= '0;
    else if (fwd) sr <= {sr[LAST-1:0], pa_in};
    else          sr <= {pb_in, sr[LAST:1]};
  end

  always_latch begin
    if (rst)       lat <= '0;
    else if (!stb) lat <= sr;
  end

  assign pa_oe  = ~fwd;
  assign pb_oe  = fwd;
  assign pa_out = sr[0];
  assign pb_out = sr[LAST];
  assign drv    = blank ? {NCH{pol}} : (lat ^ {NCH{pol}});

  p_fwd_shift_r1: assert property (@(posedge sclk) disable iff (rst)
    fwd |=> (sr[0] == $past(pa_in)) && (sr[LAST:1] == $past(sr[LAST-1:0])));

  p_rev_shift_r2: assert property (@(posedge sclk) disable iff (rst)
    !fwd |=> (sr[LAST] == $past(pb_in)) && (sr[LAST-1:0] == $past(sr[LAST:1])));

  p_pin_roles_r3: assert property (@(posedge sclk) disable iff (rst)
    $countones({pa_oe, pb_oe}) == 1);

  p_transparent_r5: assert property (@(posedge sclk) disable iff (rst)
    !stb |-> lat == sr);

  p_hold_r6: assert property (@(posedge sclk) disable iff (rst)
    stb && $past(stb) |-> $stable(lat));

  p_blank_r7: assert property (@(posedge sclk) disable iff (rst)
    blank |-> $countones(drv) == (pol ? NCH : 0));

  p_polarity_r8: assert property (@(posedge sclk) disable iff (rst)
    !blank |-> (drv ^ lat) == {NCH{pol}});
endmodule

// File: tb/row_scan_driver_test.sv
module row_scan_driver_test;
  localparam int N = 64;

  logic sclk = 0;
  logic rst = 1, fwd = 1, stb = 0, blank = 0, pol = 0;
  logic ext_a = 0, ext_b = 0;
  logic a0_out, a0_oe, b0_out, b0_oe, a1_out, a1_oe, b1_out, b1_oe;
  logic [N-1:0] drv0, drv1;

  logic [2*N-1:0] m;
  logic [2*N-1:0] ml;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 sclk = ~sclk;

  row_scan_driver #(.NCH(N)) uut (
    .sclk(sclk), .rst(rst), .fwd(fwd), .stb(stb), .blank(blank), .pol(pol),
    .pa_in(ext_a), .pa_out(a0_out), .pa_oe(a0_oe),
    .pb_in(a1_out), .pb_out(b0_out), .pb_oe(b0_oe), .drv(drv0));

  row_scan_driver #(.NCH(N)) uut_b (
    .sclk(sclk), .rst(rst), .fwd(fwd), .stb(stb), .blank(blank), .pol(pol),
    .pa_in(b0_out), .pa_out(a1_out), .pa_oe(a1_oe),
    .pb_in(ext_b), .pb_out(b1_out), .pb_oe(b1_oe), .drv(drv1));

  function automatic logic [2*N-1:0] exp_drv();
    if (blank) return {2*N{pol}};
    return ml ^ {2*N{pol}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic upd_latch();
    if (rst) ml = '0;
    else if (!stb) ml = m;
  endtask

  task automatic check_all(input string req);
    logic [2*N-1:0] e;
    e = exp_drv();
    chk({drv1, drv0} === e, req, {drv1, drv0}, e);
    chk({a0_out, b1_out} === {m[0], m[2*N-1]}, "R3/R4 serial ends", {a0_out, b1_out}, {m[0], m[2*N-1]});
    chk({a0_oe, b0_oe, a1_oe, b1_oe} === {!fwd, fwd, !fwd, fwd}, "R3 enables",
        {a0_oe, b0_oe, a1_oe, b1_oe}, {!fwd, fwd, !fwd, fwd});
  endtask

  task automatic cyc(input string req);
    @(posedge sclk);
    if (rst) m = '0;
    else if (fwd) m = {m[2*N-2:0], ext_a};
    else m = {ext_b, m[2*N-1:1]};
    upd_latch();
    #1 check_all(req);
    @(negedge sclk);
  endtask

  task automatic setin(input logic f, input logic s, input logic b, input logic p, input logic da, input logic db);
    fwd = f; stb = s; blank = b; pol = p; ext_a = da; ext_b = db;
    upd_latch();
    #1 check_all("R5/R7/R8 async");
  endtask

  initial begin
    void'($urandom(32'd2024));
    m = '0; ml = '0;
    @(negedge sclk);
    cyc("R9 reset");
    cyc("R9 reset");
    rst = 0;
    upd_latch();
    chk({drv1, drv0} === '0, "R9 cleared outputs", {drv1, drv0}, '0);

    // R1 R4: forward, marker bit through both devices
    setin(1, 0, 0, 0, 1, 0);
    cyc("R1 first");
    ext_a = 0;
    for (int i = 1; i < N; i++) cyc("R1 fwd");
    chk(b0_out === 1'b1, "R4 first device out", {127'b0, b0_out}, 1);
    for (int i = 0; i < N; i++) cyc("R4 chain fwd");
    chk(b1_out === 1'b1, "R4 chain out fwd", {127'b0, b1_out}, 1);

    // R2 R4: reverse, marker from the far end
    setin(0, 0, 0, 0, 0, 1);
    cyc("R2 first");
    ext_b = 0;
    for (int i = 1; i < 2 * N; i++) cyc("R2 rev");
    chk(a0_out === 1'b1, "R4 chain out rev", {127'b0, a0_out}, 1);

    // R6: hold while shifting with strobe high
    setin(1, 0, 0, 0, 1, 0);
    for (int i = 0; i < 10; i++) cyc("R5 load");
    setin(1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) cyc("R6 hold");
    setin(1, 1, 0, 1, 0, 0);
    cyc("R8 inverted hold");
    setin(1, 1, 1, 1, 0, 0);
    cyc("R7 blank high");
    setin(1, 1, 1, 0, 0, 0);
    cyc("R7 blank low");
    setin(1, 0, 0, 0, 0, 0);
    cyc("R5 release");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic f;
      f = ($urandom % 64 == 0) ? !fwd : fwd;
      setin(f, ($urandom % 4) == 0, ($urandom % 6) == 0, $urandom % 2, $urandom % 2, $urandom % 2);
      cyc("R1/R2/R5/R6/R7/R8 random");
    end

    // R9: reset mid-run
    rst = 1;
    upd_latch();
    cyc("R9 reset again");
    rst = 0;
    setin(1, 0, 0, 0, 0, 0);
    chk({drv1, drv0} === '0, "R9 cleared again", {drv1, drv0}, '0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #1500000;
        fails++;
        tests++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule